// File: doc/BRIEF.md
# Host Bridge Configuration Register File

This block holds the 256-byte type-0 configuration header and device-specific register space of a host-to-PCI bridge. A configuration access engine, which decodes bus configuration cycles elsewhere, drives a simple byte-wide port: a write strobe with an address and a data byte, and a read strobe whose data returns combinationally in the same cycle. Every byte location follows its own write rule. Some are read-only constants. Some are fully writable. Some keep only selected bits of a write. The upper status byte mixes sticky error flags, cleared by writing ones, with one bit that takes the written value. The memory bank bytes are derived from hardware inputs.

The whole register image is presented as a flat vector for the rest of the bridge to decode. Three one-cycle update pulses tell downstream logic that a write has landed in one of three groups: the legacy shadow control bytes, the system-management memory control byte, or the graphics aperture bytes. The asynchronous active-low reset is released inside the block through a two-stage synchronizer.

Top module: `hb_cfg_space`

## Requirements
- R1: After reset, bytes 00h–03h read 39h, 10h, 00h, 56h. Byte 04h reads 05h, 07h reads 02h, 08h reads 10h, 0Bh reads 06h, 0Dh reads FFh, 0Eh reads 80h, 34h reads C0h and 8Dh reads 62h.
- R2: A write to byte 04h changes only bit 1, which takes the written bit; all other bits keep their value.
- R3: A write to byte 05h stores written bits 1:0 and forces bits 7:2 to zero.
- R4: In byte 07h, err_set[i] sets bit 4+i. Writing a one to any of bits 6:4 clears that bit, bit 0 takes the written value, and bits 7, 3:1 are unchanged. A hardware set wins over a clear in the same cycle.
- R5: Bytes 0Dh, 50h–5Ah, 64h–69h, 6Bh–6Ch, 74h–75h, 77h–80h, 82h–8Fh, 97h–9Bh, C8h–CBh, D4h–D8h, DAh, E0h and E2h–E3h store the full written byte.
- R6: A write to any address not named in R2–R5 or R9 leaves that byte unchanged.
- R7: Byte 60h+i (i = 0..2) reads C0h OR the size code of bank i when bank_present[i] is 1, and C0h when it is 0. Writes have no effect. The size code is selected by bank_size_idx[3i+2:3i]: index 0..6 gives 00h, 20h, 24h, 22h, 26h, 2Ah, 2Bh (8, 16, 32, 64, 128, 256, 512 MB), and index 7 gives 00h.
- R8: Byte 63h reads {5'b0, bank_present[2:0]}, and writes have no effect.
- R9: Byte 12h stores only written bits 7:6, with the other bits zero. Byte 94h stores written bits 6:0, with bit 7 zero. Bytes 13h, 6Ah, 70h–73h and 91h–93h store the full byte.
- R10: With cfg_rd high, cfg_rdata shows the current byte at cfg_addr in the same cycle. With cfg_rd low, cfg_rdata is 00h.
- R11: The clock edge that accepts a write raises exactly one pulse, lasting one cycle: shadow_upd for 70h–73h, smram_upd for 6Ah, aper_upd for 12h, 13h and 91h–94h. A write to any other address raises no pulse.
- R12: cfg_image[8k+7:8k] always equals the value a read of address k would return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe, one cycle per write |
| cfg_rd | input | 1 | Read strobe |
| cfg_addr | input | 8 | Byte address |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data, valid in the strobe cycle |
| bank_present | input | 3 | Memory bank installed flags |
| bank_size_idx | input | 9 | Three 3-bit bank size indices |
| err_set | input | 3 | Hardware events that set status bits 6:4 |
| shadow_upd | output | 1 | Shadow control bytes were written |
| smram_upd | output | 1 | Management memory control byte was written |
| aper_upd | output | 1 | Aperture bytes were written |
| cfg_image | output | 2048 | Flat image of all 256 bytes |

## Verification
The hardest case to reach is the upper status byte when a hardware error event and a clear-by-writing-one arrive in the same cycle. The rule applies per bit: a set must win only for its own bit, while other bits in the same write are still cleared. To reach it, the stimulus first sets two flags through err_set. It then clears one flag and writes bit 0 in a separate write. Finally it issues a write that clears the remaining flag while err_set raises a different flag at the same edge. A read then confirms the exact byte. The bank bytes are also exercised by changing the hardware inputs between reads, with absent banks and writes that must be ignored.

// File: rtl/hb_cfg_pkg.sv
package hb_cfg_pkg;
  localparam int CFG_BYTES   = 256;
  localparam int AW          = 8;
  localparam int DW          = 8;
  localparam int NUM_BANKS   = 3;
  localparam int SIZE_IW     = 3;
  localparam int ERR_BITS    = 3;
  localparam int IMG_W       = CFG_BYTES * DW;

  localparam logic [AW-1:0] STAT_ADDR   = 8'h07;
  localparam logic [AW-1:0] BANK_BASE   = 8'h60;
  localparam logic [AW-1:0] BANK_FLAGS  = 8'h63;
  localparam logic [DW-1:0] STAT_W1C    = 8'h70;
  localparam logic [DW-1:0] STAT_WV     = 8'h01;
  localparam logic [DW-1:0] BANK_FILL   = 8'hC0;

  typedef enum logic [2:0] {WK_RO, WK_FULL, WK_MASK, WK_STAT, WK_BANK} wkind_e;
  typedef enum logic [1:0] {GRP_NONE, GRP_SHADOW, GRP_SMM, GRP_APER} ngrp_e;

  typedef struct packed {
    wkind_e          kind;
    logic [DW-1:0]   keep;
    logic [DW-1:0]   take;
    ngrp_e           grp;
  } wrule_t;

  function automatic logic [DW-1:0] reset_val(input logic [AW-1:0] a);
    case (a)
      8'h00: reset_val = 8'h39;
      8'h01: reset_val = 8'h10;
      8'h03: reset_val = 8'h56;
      8'h04: reset_val = 8'h05;
      8'h06: reset_val = 8'h10;
      8'h07: reset_val = 8'h02;
      8'h08: reset_val = 8'h10;
      8'h0B: reset_val = 8'h06;
      8'h0D: reset_val = 8'hFF;
      8'h0E: reset_val = 8'h80;
      8'h34: reset_val = 8'hC0;
      8'h50, 8'h51: reset_val = 8'h02;
      8'h84, 8'h85, 8'h86: reset_val = 8'hFF;
      8'h8D: reset_val = 8'h62;
      8'hC0: reset_val = 8'h02;
      8'hC2: reset_val = 8'h10;
      8'hC4: reset_val = 8'h03;
      8'hC5: reset_val = 8'h02;
      8'hC7: reset_val = 8'h1F;
      default: reset_val = 8'h00;
    endcase
  endfunction

  function automatic wrule_t rule_of(input logic [AW-1:0] a);
    wrule_t r;
    r = '{kind: WK_RO, keep: 8'hFF, take: 8'h00, grp: GRP_NONE};
    if (a == 8'h04)      r = '{kind: WK_MASK, keep: 8'hFD, take: 8'h02, grp: GRP_NONE};
    else if (a == 8'h05) r = '{kind: WK_MASK, keep: 8'h00, take: 8'h03, grp: GRP_NONE};
    else if (a == STAT_ADDR) r.kind = WK_STAT;
    else if (a == 8'h12) r = '{kind: WK_MASK, keep: 8'h00, take: 8'hC0, grp: GRP_APER};
    else if (a == 8'h94) r = '{kind: WK_MASK, keep: 8'h00, take: 8'h7F, grp: GRP_APER};
    else if (a == 8'h13 || (a >= 8'h91 && a <= 8'h93))
      r = '{kind: WK_FULL, keep: 8'h00, take: 8'hFF, grp: GRP_APER};
    else if (a == 8'h6A) r = '{kind: WK_FULL, keep: 8'h00, take: 8'hFF, grp: GRP_SMM};
    else if (a >= 8'h70 && a <= 8'h73)
      r = '{kind: WK_FULL, keep: 8'h00, take: 8'hFF, grp: GRP_SHADOW};
    else if (a >= BANK_BASE && a <= BANK_FLAGS) r.kind = WK_BANK;
    else if (a inside {8'h0D, [8'h50:8'h5A], [8'h64:8'h69], [8'h6B:8'h6C],
                       [8'h74:8'h75], [8'h77:8'h80], [8'h82:8'h8F],
                       [8'h97:8'h9B], [8'hC8:8'hCB], [8'hD4:8'hD8],
                       8'hDA, 8'hE0, [8'hE2:8'hE3]})
      r = '{kind: WK_FULL, keep: 8'h00, take: 8'hFF, grp: GRP_NONE};
    return r;
  endfunction

  function automatic logic [DW-1:0] size_code(input logic [SIZE_IW-1:0] idx);
    case (idx)
      3'd1: size_code = 8'h20;
      3'd2: size_code = 8'h24;
      3'd3: size_code = 8'h22;
      3'd4: size_code = 8'h26;
      3'd5: size_code = 8'h2A;
      3'd6: size_code = 8'h2B;
      default: size_code = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/hb_cfg_byte.sv
module hb_cfg_byte
  import hb_cfg_pkg::*;
#(
  parameter logic [AW-1:0] ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hit,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] hw_set,
  output logic [DW-1:0] q
);
  localparam wrule_t        RULE = rule_of(ADDR);
  localparam logic [DW-1:0] RST  = reset_val(ADDR);

  generate
    if (RULE.kind == WK_RO || RULE.kind == WK_BANK) begin : g_const
      logic unused_in;
      assign unused_in = ^{wr_hit, wdata, hw_set};
      assign q = RST;
    end else begin : g_reg
      logic [DW-1:0] q_r;
      logic [DW-1:0] q_nxt;
      logic          q_en;

      always_comb begin
        q_nxt = q_r;
        case (RULE.kind)
          WK_FULL: if (wr_hit) q_nxt = wdata;
          WK_MASK: if (wr_hit) q_nxt = (q_r & RULE.keep) | (wdata & RULE.take);
          WK_STAT: begin
            if (wr_hit)
              q_nxt = (q_r & ~(wdata & STAT_W1C) & ~STAT_WV) | (wdata & STAT_WV);
            q_nxt = q_nxt | hw_set;
          end
          default: q_nxt = q_r;
        endcase
      end

      assign q_en = wr_hit | (|hw_set);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q_r <= RST;
        else if (q_en) q_r <= q_nxt;
      end

      assign q = q_r;
    end
  endgenerate
endmodule

// File: rtl/hb_cfg_bank.sv
module hb_cfg_bank
  import hb_cfg_pkg::*;
#(
  parameter int NB = NUM_BANKS,
  parameter int IW = SIZE_IW
) (
  input  logic [NB-1:0]    present,
  input  logic [NB*IW-1:0] size_idx,
  output logic [NB*DW-1:0] code_bytes,
  output logic [DW-1:0]    flag_byte
);
  localparam int PAD = DW - NB;

  for (genvar i = 0; i < NB; i++) begin : g_bank
    assign code_bytes[i*DW +: DW] = present[i]
        ? (size_code(size_idx[i*IW +: IW]) | BANK_FILL)
        : BANK_FILL;
  end

  assign flag_byte = {{PAD{1'b0}}, present};
endmodule

// File: rtl/hb_cfg_notify.sv
module hb_cfg_notify
  import hb_cfg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  output logic          shadow_upd,
  output logic          smram_upd,
  output logic          aper_upd
);
  logic [2:0] pls_nxt;
  logic [2:0] pls_q;
  wrule_t     rule;

  always_comb begin
    rule    = rule_of(addr);
    pls_nxt = 3'b000;
    if (wr_en) begin
      case (rule.grp)
        GRP_SHADOW: pls_nxt = 3'b100;
        GRP_SMM:    pls_nxt = 3'b010;
        GRP_APER:   pls_nxt = 3'b001;
        default:    pls_nxt = 3'b000;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pls_q <= 3'b000;
    else        pls_q <= pls_nxt;
  end

  assign shadow_upd = pls_q[2];
  assign smram_upd  = pls_q[1];
  assign aper_upd   = pls_q[0];
endmodule

// File: rtl/hb_cfg_space.sv
module hb_cfg_space
  import hb_cfg_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_wr,
  input  logic                     cfg_rd,
  input  logic [7:0]               cfg_addr,
  input  logic [7:0]               cfg_wdata,
  output logic [7:0]               cfg_rdata,
  input  logic [2:0]               bank_present,
  input  logic [8:0]               bank_size_idx,
  input  logic [2:0]               err_set,
  output logic                     shadow_upd,
  output logic                     smram_upd,
  output logic                     aper_upd,
  output logic [2047:0]            cfg_image
);
  localparam int ERR_LSB = 4;

  logic [1:0]      rst_pipe;
  logic            rst_ok;
  logic [DW-1:0]   stored [CFG_BYTES];
  logic [DW-1:0]   view   [CFG_BYTES];
  logic [NUM_BANKS*DW-1:0] bank_codes;
  logic [DW-1:0]   bank_flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ok = rst_pipe[1];

  for (genvar k = 0; k < CFG_BYTES; k++) begin : g_byte
    localparam logic [AW-1:0] K = k[AW-1:0];
    logic          hit;
    logic [DW-1:0] set_bits;
    assign hit = cfg_wr && (cfg_addr == K);
    if (K == STAT_ADDR) begin : g_stat
      assign set_bits = {{(DW-ERR_LSB-ERR_BITS){1'b0}}, err_set, {ERR_LSB{1'b0}}};
    end else begin : g_plain
      assign set_bits = '0;
    end
    hb_cfg_byte #(.ADDR(K)) u_byte (
      .clk    (clk),
      .rst_n  (rst_ok),
      .wr_hit (hit),
      .wdata  (cfg_wdata),
      .hw_set (set_bits),
      .q      (stored[k])
    );
  end

  hb_cfg_bank u_bank (
    .present    (bank_present),
    .size_idx   (bank_size_idx),
    .code_bytes (bank_codes),
    .flag_byte  (bank_flags)
  );

  hb_cfg_notify u_notify (
    .clk        (clk),
    .rst_n      (rst_ok),
    .wr_en      (cfg_wr),
    .addr       (cfg_addr),
    .shadow_upd (shadow_upd),
    .smram_upd  (smram_upd),
    .aper_upd   (aper_upd)
  );

  always_comb begin
    for (int k = 0; k < CFG_BYTES; k++) view[k] = stored[k];
    for (int b = 0; b < NUM_BANKS; b++)
      view[int'(BANK_BASE) + b] = bank_codes[b*DW +: DW];
    view[int'(BANK_FLAGS)] = bank_flags;
  end

  always_comb begin
    for (int k = 0; k < CFG_BYTES; k++) cfg_image[k*DW +: DW] = view[k];
  end

  assign cfg_rdata = cfg_rd ? view[cfg_addr] : 8'h00;
endmodule

// File: rtl/hb_cfg_checker.sv
module hb_cfg_checker (
  input logic          clk,
  input logic          rst_ok,
  input logic          cfg_wr,
  input logic          cfg_rd,
  input logic [7:0]    cfg_addr,
  input logic [7:0]    cfg_wdata,
  input logic [7:0]    cfg_rdata,
  input logic [2:0]    bank_present,
  input logic [2:0]    err_set,
  input logic          shadow_upd,
  input logic          smram_upd,
  input logic          aper_upd,
  input logic [2047:0] cfg_image
);
  p_cmdlo_keep_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    (cfg_wr && cfg_addr == 8'h04) |=>
      ((cfg_image[39:32] & 8'hFD) == ($past(cfg_image[39:32]) & 8'hFD)));

  p_cmdhi_zero_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    (cfg_wr && cfg_addr == 8'h05) |=> (cfg_image[47:42] == 6'b0));

  p_w1c_clear_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    (cfg_wr && cfg_addr == 8'h07 && cfg_wdata[5] && !err_set[1]) |=> !cfg_image[61]);

  p_sticky_set_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    err_set[2] |=> cfg_image[62]);

  p_ro_stable_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    (cfg_wr && cfg_addr == 8'h08) |=> $stable(cfg_image[71:64]));

  p_bank_fill_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    (cfg_image[775:774] == 2'b11) && (cfg_image[783:782] == 2'b11) &&
    (cfg_image[791:790] == 2'b11));

  p_flags_read_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    (cfg_rd && cfg_addr == 8'h63) |-> (cfg_rdata == {5'b0, bank_present}));

  p_idle_read_r10: assert property (@(posedge clk) disable iff (!rst_ok)
    !cfg_rd |-> (cfg_rdata == 8'h00));

  p_smm_pulse_r11: assert property (@(posedge clk) disable iff (!rst_ok)
    (cfg_wr && cfg_addr == 8'h6A) |=> smram_upd);

  p_one_pulse_r11: assert property (@(posedge clk) disable iff (!rst_ok)
    $onehot0({shadow_upd, smram_upd, aper_upd}));

  p_pulse_end_r11: assert property (@(posedge clk) disable iff (!rst_ok)
    !cfg_wr |=> !(shadow_upd || smram_upd || aper_upd));
endmodule

bind hb_cfg_space hb_cfg_checker u_chk (
  .clk          (clk),
  .rst_ok       (rst_ok),
  .cfg_wr       (cfg_wr),
  .cfg_rd       (cfg_rd),
  .cfg_addr     (cfg_addr),
  .cfg_wdata    (cfg_wdata),
  .cfg_rdata    (cfg_rdata),
  .bank_present (bank_present),
  .err_set      (err_set),
  .shadow_upd   (shadow_upd),
  .smram_upd    (smram_upd),
  .aper_upd     (aper_upd),
  .cfg_image    (cfg_image)
);

// File: tb/sim_hb_cfg_space.sv
`timescale 1ns/1ps
module sim_hb_cfg_space;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr = 1'b0;
  logic          cfg_rd = 1'b0;
  logic [7:0]    cfg_addr = 8'h00;
  logic [7:0]    cfg_wdata = 8'h00;
  logic [7:0]    cfg_rdata;
  logic [2:0]    bank_present = 3'b101;
  logic [8:0]    bank_size_idx = {3'd3, 3'd2, 3'd6};
  logic [2:0]    err_set = 3'b000;
  logic          shadow_upd, smram_upd, aper_upd;
  logic [2047:0] cfg_image;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] addr;
    logic [7:0] exp;
    string      tag;
  } rd_item_t;
  rd_item_t sb[$];

  always #10 clk = ~clk;

  hb_cfg_space u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .bank_present(bank_present), .bank_size_idx(bank_size_idx),
    .err_set(err_set), .shadow_upd(shadow_upd), .smram_upd(smram_upd),
    .aper_upd(aper_upd), .cfg_image(cfg_image)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read items at the mid-cycle sample point
  always @(negedge clk) begin
    if (cfg_rd) begin
      if (sb.size() == 0) begin
        check("scoreboard underflow", 8'h00, 8'h01);
      end else begin
        rd_item_t it;
        it = sb.pop_front();
        check($sformatf("%s addr %02h", it.tag, it.addr), cfg_rdata, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #2;
    cfg_wr = 1'b0;
  endtask

  task automatic wr_pulse(input logic [7:0] a, input logic [7:0] d,
                          input logic [2:0] exp, input string tag);
    wr(a, d);
    @(negedge clk);
    check(tag, {5'b0, shadow_upd, smram_upd, aper_upd}, {5'b0, exp});
    @(negedge clk);
    check({tag, " end"}, {5'b0, shadow_upd, smram_upd, aper_upd}, 8'h00);
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    rd_item_t it;
    @(posedge clk); #2;
    it.addr = a; it.exp = exp; it.tag = tag;
    sb.push_back(it);
    cfg_rd = 1'b1; cfg_addr = a;
    @(posedge clk); #2;
    cfg_rd = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset values
    rd(8'h00, 8'h39, "R1 id0");
    rd(8'h01, 8'h10, "R1 id1");
    rd(8'h03, 8'h56, "R1 id3");
    rd(8'h04, 8'h05, "R1 cmdlo");
    rd(8'h07, 8'h02, "R1 stat");
    rd(8'h08, 8'h10, "R1 rev");
    rd(8'h0B, 8'h06, "R1 class");
    rd(8'h0D, 8'hFF, "R1 lat");
    rd(8'h0E, 8'h80, "R1 hdr");
    rd(8'h34, 8'hC0, "R1 cap");
    rd(8'h8D, 8'h62, "R1 8d");

    // R2 command low byte
    wr(8'h04, 8'hFF); rd(8'h04, 8'h07, "R2 set bit1");
    wr(8'h04, 8'h00); rd(8'h04, 8'h05, "R2 clr bit1");

    // R3 command high byte
    wr(8'h05, 8'hFF); rd(8'h05, 8'h03, "R3 mask");

    // R4 status high byte
    @(posedge clk); #2 err_set = 3'b101;
    @(posedge clk); #2 err_set = 3'b000;
    rd(8'h07, 8'h52, "R4 hw set");
    wr(8'h07, 8'h11); rd(8'h07, 8'h43, "R4 w1c and bit0");
    @(posedge clk); #2;
    cfg_wr = 1'b1; cfg_addr = 8'h07; cfg_wdata = 8'h40; err_set = 3'b001;
    @(posedge clk); #2;
    cfg_wr = 1'b0; err_set = 3'b000;
    rd(8'h07, 8'h12, "R4 set and clear same edge");

    // R5 full bytes
    wr(8'h50, 8'hA5); rd(8'h50, 8'hA5, "R5 50");
    wr(8'h8F, 8'h3C); rd(8'h8F, 8'h3C, "R5 8f");
    wr(8'hDA, 8'h77); rd(8'hDA, 8'h77, "R5 da");
    wr(8'hE3, 8'h81); rd(8'hE3, 8'h81, "R5 e3");
    wr(8'h0D, 8'h12); rd(8'h0D, 8'h12, "R5 0d");

    // R6 ignored writes
    wr(8'h00, 8'hFF); rd(8'h00, 8'h39, "R6 00");
    wr(8'h81, 8'hFF); rd(8'h81, 8'h00, "R6 81");
    wr(8'h76, 8'hFF); rd(8'h76, 8'h00, "R6 76");
    wr(8'hD9, 8'hFF); rd(8'hD9, 8'h00, "R6 d9");
    wr(8'h08, 8'hFF); rd(8'h08, 8'h10, "R6 08");
    wr(8'hC0, 8'hFF); rd(8'hC0, 8'h02, "R6 c0");

    // R7 / R8 bank bytes
    rd(8'h60, 8'hEB, "R7 bank0 512MB");
    rd(8'h61, 8'hC0, "R7 bank1 absent");
    rd(8'h62, 8'hE2, "R7 bank2 64MB");
    rd(8'h63, 8'h05, "R8 flags");
    wr(8'h60, 8'h00); rd(8'h60, 8'hEB, "R7 write ignored");
    wr(8'h63, 8'hFF); rd(8'h63, 8'h05, "R8 write ignored");
    bank_size_idx = {3'd3, 3'd2, 3'd2};
    bank_present  = 3'b011;
    rd(8'h60, 8'hE4, "R7 bank0 32MB");
    rd(8'h61, 8'hE4, "R7 bank1 32MB");
    rd(8'h62, 8'hC0, "R7 bank2 absent");
    rd(8'h63, 8'h03, "R8 flags change");

    // R9 masked and group bytes, R11 pulses
    wr_pulse(8'h12, 8'hFF, 3'b001, "R11 aper 12");
    rd(8'h12, 8'hC0, "R9 12");
    wr_pulse(8'h94, 8'hFF, 3'b001, "R11 aper 94");
    rd(8'h94, 8'h7F, "R9 94");
    wr(8'h13, 8'h5A); rd(8'h13, 8'h5A, "R9 13");
    wr_pulse(8'h6A, 8'h9C, 3'b010, "R11 smm 6a");
    rd(8'h6A, 8'h9C, "R9 6a");
    wr_pulse(8'h71, 8'h33, 3'b100, "R11 shadow 71");
    rd(8'h71, 8'h33, "R9 71");
    wr_pulse(8'h92, 8'hE1, 3'b001, "R11 aper 92");
    rd(8'h92, 8'hE1, "R9 92");
    wr_pulse(8'h50, 8'h11, 3'b000, "R11 no pulse 50");

    // R10 idle read data
    @(negedge clk);
    check("R10 idle rdata", cfg_rdata, 8'h00);

    // R12 image matches reads
    @(negedge clk);
    check("R12 image 50", cfg_image[8'h50*8 +: 8], 8'h11);
    check("R12 image 60", cfg_image[8'h60*8 +: 8], 8'hE4);
    check("R12 image 07", cfg_image[8'h07*8 +: 8], 8'h12);

    repeat (3) @(posedge clk);
    check("scoreboard drained", 8'(sb.size()), 8'h00);
    finish_run();
  end
endmodule